// File: doc/BRIEF.md
# Two-Wire Control and Status Register Bank

This block is a two-wire (I2C) target that lets a board controller read a handful of status flags from a receive datapath and write the control fields that steer it. The bus pins are sampled in the system clock domain. Each pin passes through a synchroniser and a short majority-free glitch window before start, stop and clock edges are detected. The target answers a 7-bit address whose bit 5 comes from a strap input, so two copies can share a bus.

Every transfer begins with an 8-bit register pointer written after the address byte. Data bytes that follow it are stored at the pointer, and the pointer advances after each byte. A read sets the pointer with a short write, then issues a repeated start with the read bit set. The two control registers cannot be read where they are written; each has its own mirror address for read-back. Three bits of the second control register are edge commands: storing a 0 over a stored 1 emits a single-clock pulse to the datapath. A signed sample-phase code is clamped into a symmetric legal window as it is written.

Top module: `i2c_ctrl_regbank`

## Requirements
- R1: The target acknowledges only the 7-bit address whose bits are, from MSB to LSB, 1, the strap input, 0, 0, 0, 0, 0. Any other address gets no acknowledge, SDA stays released for the rest of that transfer, and no register changes.
- R2: In a write transfer (start, address with R/W = 0, pointer byte, data bytes, stop), the target acknowledges the pointer and every data byte. Each data byte is stored at the pointer, and the pointer then advances by one.
- R3: In a read transfer (pointer write, repeated start, address with R/W = 1), the target shifts out the byte at the pointer MSB first and advances the pointer. It sends the next byte after each master acknowledge. After a master no-acknowledge it releases SDA and sends nothing more.
- R4: Pointer 0x04 reads status as {0, 0, signal-lost, sticky-lock-loss, acquiring, measurement-done, 0, coarse-rate LSB} from bit 7 down to bit 0.
- R5: The control byte written at pointer 0x08 appears on ctrl_a_o and reads back at 0x05. The byte written at 0x09 appears on ctrl_b_o and reads back at 0x06.
- R6: Pointer 0x09 bits 6, 5 and 3 drive pulse_clr_lock_o, pulse_acq_o and pulse_clr_meas_o. A pulse is exactly one clock long and fires only when a write stores 0 into a bit that held 1. A 1 written over anything, or a 0 over a 0, fires nothing.
- R7: A write to pointer 0x1E takes bits 5:0 as a two's-complement code and clamps it to the range -30..+30 onto phase_o. Bits 7:6 are ignored, so -32 and -31 become -30 (6'b100010), and +31 becomes +30.
- R8: A pointer value with no write function (anything other than 0x08, 0x09, 0x1E) is still acknowledged on write, and the byte is discarded. A pointer value with no read function (anything other than 0x04, 0x05, 0x06, including 0x08, 0x09 and 0x1E) reads 0x00.
- R9: A low or high pulse of one system clock on SCL or SDA is ignored: it creates no bit, start or stop.
- R10: After reset, ctrl_a_o, ctrl_b_o and phase_o are 0, no pulse is active, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock pin level |
| sda_i | input | 1 | Bus data pin level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_pin_i | input | 1 | Strap selecting address bit 5 |
| sig_lost_i | input | 1 | Status: input signal lost |
| lock_sticky_i | input | 1 | Status: sticky lock-loss flag |
| acquiring_i | input | 1 | Status: loop not locked |
| meas_done_i | input | 1 | Status: rate measurement finished |
| coarse_lsb_i | input | 1 | Status: LSB of coarse rate value |
| ctrl_a_o | output | 8 | First control byte |
| ctrl_b_o | output | 8 | Second control byte |
| phase_o | output | 6 | Clamped signed sample-phase code |
| pulse_clr_lock_o | output | 1 | Command pulse from bit 6 of the second control byte |
| pulse_acq_o | output | 1 | Command pulse from bit 5 of the second control byte |
| pulse_clr_meas_o | output | 1 | Command pulse from bit 3 of the second control byte |

## Verification
A wrong byte-engine state shows up first as a missing or misplaced acknowledge. The master samples that within one bus bit of the fault, and the next read-back then returns shifted or wrong data. A stale or corrupted control register appears on its output port from the clock after the stop, and the reference model compares those ports on every clock. A wrong command bit appears either as a pulse count mismatch right after the transfer or as a pulse longer than one clock, seen at once.

// File: rtl/i2c_regbank_pkg.sv
package i2c_regbank_pkg;

   localparam logic [7:0] PTR_STATUS = 8'h04;
   localparam logic [7:0] PTR_RB_A   = 8'h05;
   localparam logic [7:0] PTR_RB_B   = 8'h06;
   localparam logic [7:0] PTR_CTL_A  = 8'h08;
   localparam logic [7:0] PTR_CTL_B  = 8'h09;
   localparam logic [7:0] PTR_PHASE  = 8'h1E;

   localparam int NUM_PULSE = 3;

   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_ADDR,
      BUS_AACK,
      BUS_PTR,
      BUS_WDAT,
      BUS_WACK,
      BUS_RDAT,
      BUS_MACK
   } bus_state_t;

   typedef struct packed {
      logic sig_lost;
      logic lock_sticky;
      logic acquiring;
      logic meas_done;
      logic coarse_lsb;
   } status_t;

endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic line_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_line_cond: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("i2c_line_cond: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign synced = sync_q[SYNC_STAGES-1];

   if (FILT_LEN > 1) begin : g_window
      logic [FILT_LEN-1:0] win_q;
      logic                line_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            win_q  <= '1;
            line_q <= 1'b1;
         end else begin
            win_q <= {win_q[FILT_LEN-2:0], synced};
            if (&win_q)       line_q <= 1'b1;
            else if (~|win_q) line_q <= 1'b0;
         end
      end
      assign line_o = line_q;

      // R9: the filtered level only moves after a full window agreed on it
      a_r9_filter_agrees: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(line_q) |-> ($past(win_q) == {FILT_LEN{line_q}}));
   end else begin : g_pass
      assign line_o = synced;
   end

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import i2c_regbank_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR_BASE = 7'h40,
   parameter int         ADDR_PIN_POS  = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       addr_pin_i,
   input  logic [7:0] rd_data_i,
   output logic [7:0] rd_ptr_o,
   output logic       sda_low_o,
   output logic       wr_en_o,
   output logic [7:0] wr_ptr_o,
   output logic [7:0] wr_data_o
);

   if (ADDR_PIN_POS < 0 || ADDR_PIN_POS > 6) begin : g_bad_pos
      $error("i2c_byte_engine: ADDR_PIN_POS must be within 0..6");
   end

   localparam logic [6:0] PIN_MASK  = 7'(1) << ADDR_PIN_POS;
   localparam logic [6:0] BASE_ONLY = DEV_ADDR_BASE & ~PIN_MASK;
   localparam logic [3:0] BYTE_BITS = 4'd8;

   bus_state_t state;
   logic [3:0] cnt;
   logic [7:0] rx, tx, ptr;
   logic       rw, more, sda_low;
   logic       scl_d, sda_d;
   logic       wr_en;
   logic [7:0] wr_ptr, wr_data;
   logic [6:0] my_addr;

   logic scl_rise, scl_fall, start_evt, stop_evt;

   assign my_addr   = BASE_ONLY | (addr_pin_i ? PIN_MASK : 7'd0);
   assign scl_rise  = scl_i & ~scl_d;
   assign scl_fall  = ~scl_i & scl_d;
   assign start_evt = scl_i & scl_d & sda_d & ~sda_i;
   assign stop_evt  = scl_i & scl_d & ~sda_d & sda_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= BUS_IDLE;
         cnt     <= '0;
         rx      <= '0;
         tx      <= '0;
         ptr     <= '0;
         rw      <= 1'b0;
         more    <= 1'b0;
         sda_low <= 1'b0;
         scl_d   <= 1'b1;
         sda_d   <= 1'b1;
         wr_en   <= 1'b0;
         wr_ptr  <= '0;
         wr_data <= '0;
      end else begin
         scl_d <= scl_i;
         sda_d <= sda_i;
         wr_en <= 1'b0;
         if (start_evt) begin
            state   <= BUS_ADDR;
            cnt     <= '0;
            sda_low <= 1'b0;
         end else if (stop_evt) begin
            state   <= BUS_IDLE;
            sda_low <= 1'b0;
         end else begin
            case (state)
               BUS_ADDR, BUS_PTR, BUS_WDAT: begin
                  if (scl_rise && cnt != BYTE_BITS) begin
                     rx  <= {rx[6:0], sda_i};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == BYTE_BITS) begin
                     cnt <= '0;
                     if (state == BUS_ADDR) begin
                        if (rx[7:1] == my_addr) begin
                           rw      <= rx[0];
                           sda_low <= 1'b1;
                           state   <= BUS_AACK;
                        end else begin
                           state <= BUS_IDLE;
                        end
                     end else if (state == BUS_PTR) begin
                        ptr     <= rx;
                        sda_low <= 1'b1;
                        state   <= BUS_WACK;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_ptr  <= ptr;
                        wr_data <= rx;
                        ptr     <= ptr + 8'd1;
                        sda_low <= 1'b1;
                        state   <= BUS_WACK;
                     end
                  end
               end
               BUS_AACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        tx      <= rd_data_i;
                        sda_low <= ~rd_data_i[7];
                        ptr     <= ptr + 8'd1;
                        cnt     <= 4'd1;
                        state   <= BUS_RDAT;
                     end else begin
                        sda_low <= 1'b0;
                        state   <= BUS_PTR;
                     end
                  end
               end
               BUS_WACK: begin
                  if (scl_fall) begin
                     sda_low <= 1'b0;
                     state   <= BUS_WDAT;
                  end
               end
               BUS_RDAT: begin
                  if (scl_fall) begin
                     if (cnt == BYTE_BITS) begin
                        sda_low <= 1'b0;
                        state   <= BUS_MACK;
                     end else begin
                        tx      <= {tx[6:0], 1'b0};
                        sda_low <= ~tx[6];
                        cnt     <= cnt + 4'd1;
                     end
                  end
               end
               BUS_MACK: begin
                  if (scl_rise) begin
                     more <= ~sda_i;
                  end else if (scl_fall) begin
                     if (more) begin
                        tx      <= rd_data_i;
                        sda_low <= ~rd_data_i[7];
                        ptr     <= ptr + 8'd1;
                        cnt     <= 4'd1;
                        state   <= BUS_RDAT;
                     end else begin
                        state <= BUS_IDLE;
                     end
                  end
               end
               default: sda_low <= 1'b0;
            endcase
         end
      end
   end

   assign rd_ptr_o  = ptr;
   assign sda_low_o = sda_low;
   assign wr_en_o   = wr_en;
   assign wr_ptr_o  = wr_ptr;
   assign wr_data_o = wr_data;

   // R1: an unaddressed or idle target never holds the line
   a_r1_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BUS_IDLE) |-> !sda_low);

   // R3: a stop condition always frees the data line on the next clock
   a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_low);

   // R2: a store only follows a completed data byte
   a_r2_store_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(state) == BUS_WDAT && state == BUS_WACK));

endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
   import i2c_regbank_pkg::*;
#(
   parameter int                              PHASE_MAX = 30,
   parameter logic [NUM_PULSE-1:0][2:0]       PULSE_POS = {3'd3, 3'd5, 3'd6}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [7:0]           wr_ptr_i,
   input  logic [7:0]           wr_data_i,
   input  logic [7:0]           rd_ptr_i,
   input  status_t              status_i,
   output logic [7:0]           rd_data_o,
   output logic [7:0]           ctrl_a_o,
   output logic [7:0]           ctrl_b_o,
   output logic [5:0]           phase_o,
   output logic [NUM_PULSE-1:0] pulse_o
);

   if (PHASE_MAX < 0 || PHASE_MAX > 31) begin : g_bad_lim
      $error("i2c_ctrl_regs: PHASE_MAX must be within 0..31");
   end

   localparam logic signed [6:0] LIM_HI = 7'(PHASE_MAX);
   localparam logic signed [6:0] LIM_LO = -LIM_HI;

   logic [7:0] ctrl_a_q, ctrl_b_q;
   logic [5:0] phase_q, phase_clamped;
   logic signed [6:0] phase_in;
   logic wr_a, wr_b, wr_ph;

   assign wr_a  = wr_en_i && (wr_ptr_i == PTR_CTL_A);
   assign wr_b  = wr_en_i && (wr_ptr_i == PTR_CTL_B);
   assign wr_ph = wr_en_i && (wr_ptr_i == PTR_PHASE);

   assign phase_in = {wr_data_i[5], wr_data_i[5:0]};

   always_comb begin
      if (phase_in > LIM_HI)      phase_clamped = LIM_HI[5:0];
      else if (phase_in < LIM_LO) phase_clamped = LIM_LO[5:0];
      else                        phase_clamped = phase_in[5:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_a_q <= '0;
         ctrl_b_q <= '0;
         phase_q  <= '0;
      end else begin
         if (wr_a)  ctrl_a_q <= wr_data_i;
         if (wr_b)  ctrl_b_q <= wr_data_i;
         if (wr_ph) phase_q  <= phase_clamped;
      end
   end

   for (genvar k = 0; k < NUM_PULSE; k++) begin : g_pulse
      logic p_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) p_q <= 1'b0;
         else        p_q <= wr_b && ctrl_b_q[PULSE_POS[k]] && !wr_data_i[PULSE_POS[k]];
      end
      assign pulse_o[k] = p_q;

      // R6: a command pulse lasts a single clock
      a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
         p_q |=> !p_q);

      // R6: a pulse means the stored command bit just went from 1 to 0
      a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
         p_q |-> ($past(ctrl_b_q[PULSE_POS[k]]) && !ctrl_b_q[PULSE_POS[k]]));
   end

   always_comb begin
      case (rd_ptr_i)
         PTR_STATUS: rd_data_o = {2'b00, status_i.sig_lost, status_i.lock_sticky,
                                  status_i.acquiring, status_i.meas_done,
                                  1'b0, status_i.coarse_lsb};
         PTR_RB_A:   rd_data_o = ctrl_a_q;
         PTR_RB_B:   rd_data_o = ctrl_b_q;
         default:    rd_data_o = 8'h00;
      endcase
   end

   assign ctrl_a_o = ctrl_a_q;
   assign ctrl_b_o = ctrl_b_q;
   assign phase_o  = phase_q;

   // R7: the stored phase code never leaves the legal window
   a_r7_phase_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed({phase_q[5], phase_q}) <= LIM_HI) && ($signed({phase_q[5], phase_q}) >= LIM_LO));

endmodule

// File: rtl/i2c_ctrl_regbank.sv
module i2c_ctrl_regbank
   import i2c_regbank_pkg::*;
#(
   parameter int         SYNC_STAGES   = 2,
   parameter int         FILT_LEN      = 3,
   parameter logic [6:0] DEV_ADDR_BASE = 7'h40,
   parameter int         ADDR_PIN_POS  = 5,
   parameter int         PHASE_MAX     = 30
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic       addr_pin_i,
   input  logic       sig_lost_i,
   input  logic       lock_sticky_i,
   input  logic       acquiring_i,
   input  logic       meas_done_i,
   input  logic       coarse_lsb_i,
   output logic [7:0] ctrl_a_o,
   output logic [7:0] ctrl_b_o,
   output logic [5:0] phase_o,
   output logic       pulse_clr_lock_o,
   output logic       pulse_acq_o,
   output logic       pulse_clr_meas_o
);

   logic scl_f, sda_f;
   logic [7:0] rd_ptr, rd_data, wr_ptr, wr_data;
   logic wr_en;
   logic [NUM_PULSE-1:0] pulses;
   status_t status;

   assign status = '{sig_lost: sig_lost_i, lock_sticky: lock_sticky_i,
                     acquiring: acquiring_i, meas_done: meas_done_i,
                     coarse_lsb: coarse_lsb_i};

   i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl (
      .clk(clk), .rst_n(rst_n), .raw_i(scl_i), .line_o(scl_f));

   i2c_line_cond #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda (
      .clk(clk), .rst_n(rst_n), .raw_i(sda_i), .line_o(sda_f));

   i2c_byte_engine #(.DEV_ADDR_BASE(DEV_ADDR_BASE), .ADDR_PIN_POS(ADDR_PIN_POS)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
      .addr_pin_i(addr_pin_i), .rd_data_i(rd_data), .rd_ptr_o(rd_ptr),
      .sda_low_o(sda_pull_o), .wr_en_o(wr_en), .wr_ptr_o(wr_ptr),
      .wr_data_o(wr_data));

   i2c_ctrl_regs #(.PHASE_MAX(PHASE_MAX)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ptr_i(wr_ptr),
      .wr_data_i(wr_data), .rd_ptr_i(rd_ptr), .status_i(status),
      .rd_data_o(rd_data), .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o),
      .phase_o(phase_o), .pulse_o(pulses));

   assign pulse_clr_lock_o = pulses[0];
   assign pulse_acq_o      = pulses[1];
   assign pulse_clr_meas_o = pulses[2];

endmodule

// File: tb/sim_i2c_ctrl_regbank.sv
`timescale 1ns/1ps
module sim_i2c_ctrl_regbank;

   localparam int Q = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic addr_pin = 1'b0;
   logic st_los = 1'b0, st_sticky = 1'b0, st_acq = 1'b0, st_done = 1'b0, st_lsb = 1'b0;
   logic sda_pull;
   logic [7:0] ctrl_a, ctrl_b;
   logic [5:0] phase;
   logic p_lock, p_acq, p_meas;
   wire  sda_line = m_sda & ~sda_pull;

   always #4 clk = ~clk;

   i2c_ctrl_regbank u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_pull_o(sda_pull), .addr_pin_i(addr_pin),
      .sig_lost_i(st_los), .lock_sticky_i(st_sticky), .acquiring_i(st_acq),
      .meas_done_i(st_done), .coarse_lsb_i(st_lsb),
      .ctrl_a_o(ctrl_a), .ctrl_b_o(ctrl_b), .phase_o(phase),
      .pulse_clr_lock_o(p_lock), .pulse_acq_o(p_acq), .pulse_clr_meas_o(p_meas));

   int checks = 0, errors = 0, cycles = 0;
   logic cmp_en = 1'b0;
   logic [7:0] exp_a = 0, exp_b = 0;
   logic [5:0] exp_ph = 0;
   int exp_cnt [3] = '{0, 0, 0};
   int got_cnt [3] = '{0, 0, 0};
   logic [2:0] prev_p = 3'b000;
   logic [7:0] wbuf [4];
   logic [7:0] rbuf [4];
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // reference model and per-clock comparison
   always @(negedge clk) begin
      logic [2:0] cur;
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         chk(0, "watchdog", cycles, 150000);
         finish_run();
      end
      cur = {p_meas, p_acq, p_lock};
      for (int k = 0; k < 3; k++) begin
         if (cur[k]) got_cnt[k]++;
         if (cur[k] && prev_p[k]) chk(0, "R6 pulse width", 2, 1);
      end
      prev_p = cur;
      if (cmp_en) begin
         chk(ctrl_a == exp_a, "R5 ctrl_a", ctrl_a, exp_a);
         chk(ctrl_b == exp_b, "R5 ctrl_b", ctrl_b, exp_b);
         chk(phase == exp_ph, "R7 phase", phase, exp_ph);
      end
   end

   function automatic logic [7:0] mdl_read(input logic [7:0] a);
      case (a)
         8'h04:   return {2'b00, st_los, st_sticky, st_acq, st_done, 1'b0, st_lsb};
         8'h05:   return exp_a;
         8'h06:   return exp_b;
         default: return 8'h00;
      endcase
   endfunction

   task automatic mdl_write(input logic [7:0] a, input logic [7:0] d);
      int v;
      if (a == 8'h08) exp_a = d;
      else if (a == 8'h09) begin
         if (exp_b[6] && !d[6]) exp_cnt[0]++;
         if (exp_b[5] && !d[5]) exp_cnt[1]++;
         if (exp_b[3] && !d[3]) exp_cnt[2]++;
         exp_b = d;
      end else if (a == 8'h1E) begin
         v = int'(d[5:0]);
         if (v >= 32) v = v - 64;
         if (v > 30) v = 30;
         if (v < -30) v = -30;
         exp_ph = 6'(v);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1; m_scl = 1; tick(Q);
      m_sda = 0; tick(Q);
      m_scl = 0; tick(Q);
   endtask

   task automatic bus_rstart();
      m_sda = 1; tick(Q);
      m_scl = 1; tick(Q);
      m_sda = 0; tick(Q);
      m_scl = 0; tick(Q);
   endtask

   task automatic bus_stop();
      m_sda = 0; tick(Q);
      m_scl = 1; tick(Q);
      m_sda = 1; tick(Q);
   endtask

   task automatic bit_tx(input logic b, input bit glitch);
      m_sda = b; tick(Q);
      m_scl = 1; tick(Q);
      if (glitch) begin m_scl = 0; tick(1); m_scl = 1; end
      tick(Q);
      m_scl = 0; tick(Q);
   endtask

   task automatic bit_rx(output logic b);
      m_sda = 1; tick(Q);
      m_scl = 1; tick(Q);
      b = sda_line; tick(Q);
      m_scl = 0; tick(Q);
   endtask

   task automatic byte_tx(input logic [7:0] d, input bit glitch, output logic ack);
      for (int i = 7; i >= 0; i--) bit_tx(d[i], glitch && i == 4);
      bit_rx(ack);
   endtask

   task automatic byte_rx(input bit mack, output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin bit_rx(b); d[i] = b; end
      bit_tx(!mack, 0);
   endtask

   task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                           input bit exp_ack, input bit glitch);
      logic ack;
      cmp_en = 0;
      bus_start();
      byte_tx({dev, 1'b0}, 0, ack);
      chk(ack == !exp_ack, "R1 address ack", ack, !exp_ack);
      if (exp_ack) begin
         byte_tx(ptr, 0, ack);
         chk(ack == 0, "R2 pointer ack", ack, 0);
         for (int i = 0; i < n; i++) begin
            byte_tx(wbuf[i], glitch && i == 0, ack);
            chk(ack == 0, "R2 data ack", ack, 0);
         end
      end else begin
         byte_tx(ptr, 0, ack);
         chk(ack == 1, "R1 ignored after mismatch", ack, 1);
      end
      bus_stop();
      tick(12);
      if (exp_ack) for (int i = 0; i < n; i++) mdl_write(8'(ptr + 8'(i)), wbuf[i]);
      tick(2);
      for (int k = 0; k < 3; k++) chk(got_cnt[k] == exp_cnt[k], "R6 pulse count", got_cnt[k], exp_cnt[k]);
      cmp_en = 1;
      tick(4);
   endtask

   task automatic do_read(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                          input string tag);
      logic ack;
      cmp_en = 0;
      bus_start();
      byte_tx({dev, 1'b0}, 0, ack);
      chk(ack == 0, "R3 address ack", ack, 0);
      byte_tx(ptr, 0, ack);
      chk(ack == 0, "R3 pointer ack", ack, 0);
      bus_rstart();
      byte_tx({dev, 1'b1}, 0, ack);
      chk(ack == 0, "R3 read address ack", ack, 0);
      for (int i = 0; i < n; i++) begin
         byte_rx(i < n - 1, rbuf[i]);
         chk(rbuf[i] == mdl_read(8'(ptr + 8'(i))), tag, rbuf[i], mdl_read(8'(ptr + 8'(i))));
      end
      tick(2);
      chk(sda_pull == 0, "R3 release after nack", sda_pull, 0);
      bus_stop();
      tick(8);
      cmp_en = 1;
      tick(4);
   endtask

   initial begin
      tick(5);
      rst_n = 1;
      tick(10);
      // R10: reset state
      chk(ctrl_a == 0 && ctrl_b == 0, "R10 ctrl reset", {ctrl_b, ctrl_a}, 0);
      chk(phase == 0, "R10 phase reset", phase, 0);
      chk(sda_pull == 0 && {p_lock, p_acq, p_meas} == 0, "R10 idle outputs", {sda_pull, p_lock, p_acq, p_meas}, 0);
      cmp_en = 1;

      // R2 R5: single write, mirror read-back
      wbuf[0] = 8'hA5;
      do_write(7'h40, 8'h08, 1, 1, 0);
      do_read(7'h40, 8'h05, 1, "R5 readback A");

      // R1: wrong address and strap change
      wbuf[0] = 8'h11;
      do_write(7'h60, 8'h08, 1, 0, 0);
      addr_pin = 1;
      tick(4);
      do_write(7'h40, 8'h08, 1, 0, 0);
      wbuf[0] = 8'h3C; wbuf[1] = 8'h68;
      do_write(7'h60, 8'h08, 2, 1, 0);

      // R3 R4: multi-byte read through status and mirrors
      st_los = 1; st_acq = 1; st_lsb = 1;
      do_read(7'h60, 8'h04, 3, "R4 status then R3 increment");
      st_los = 0; st_acq = 0; st_lsb = 0; st_sticky = 1; st_done = 1;
      do_read(7'h60, 8'h04, 1, "R4 status pattern two");
      addr_pin = 0;
      tick(4);

      // R6: command bits
      wbuf[0] = 8'h20; do_write(7'h40, 8'h09, 1, 1, 0);
      wbuf[0] = 8'h20; do_write(7'h40, 8'h09, 1, 1, 0);
      wbuf[0] = 8'h00; do_write(7'h40, 8'h09, 1, 1, 0);
      wbuf[0] = 8'hFF; do_write(7'h40, 8'h09, 1, 1, 0);
      wbuf[0] = 8'h00; do_write(7'h40, 8'h09, 1, 1, 0);

      // R7: phase clamp
      wbuf[0] = 8'h05; do_write(7'h40, 8'h1E, 1, 1, 0);
      wbuf[0] = 8'h21; do_write(7'h40, 8'h1E, 1, 1, 0);
      chk(phase == 6'h22, "R7 clamp -31", phase, 6'h22);
      wbuf[0] = 8'h1F; do_write(7'h40, 8'h1E, 1, 1, 0);
      chk(phase == 6'h1E, "R7 clamp +31", phase, 6'h1E);
      wbuf[0] = 8'hC3; do_write(7'h40, 8'h1E, 1, 1, 0);
      wbuf[0] = 8'h20; do_write(7'h40, 8'h1E, 1, 1, 0);

      // R8: unmapped and write-only pointers
      wbuf[0] = 8'hFF; do_write(7'h40, 8'h10, 1, 1, 0);
      do_read(7'h40, 8'h10, 1, "R8 unmapped read");
      do_read(7'h40, 8'h08, 2, "R8 write-only reads zero");
      do_read(7'h40, 8'h1E, 1, "R8 phase pointer reads zero");

      // R9: one-clock glitches on SDA in idle and on SCL mid-bit
      m_sda = 0; tick(1); m_sda = 1; tick(Q);
      chk(sda_pull == 0, "R9 idle SDA glitch", sda_pull, 0);
      wbuf[0] = 8'h5A; do_write(7'h40, 8'h08, 1, 1, 1);
      do_read(7'h40, 8'h05, 1, "R9 write with SCL glitch");

      done = 1;
      finish_run();
   end

endmodule